// File: doc/BRIEF.md
# Interrupt and Event Sleep Controller

This block collects up to 32 interrupt lines and 32 event lines into two separate pending banks, each with its own enable mask. A rising edge on a line whose enable bit is set latches that line's pending bit. Software can also write the pending register directly, or change it through write-one set and write-one clear registers. The OR of the pending interrupts that are still enabled drives the interrupt request to the core. Pending events never reach that request. They only serve to wake the core.

A sleep state machine drives the core clock-gate enable. The machine has three states:
- **RUN**: the clock runs. A sleep-control bit set to 1 moves the machine to **SLEEP** on the next clock edge. This transition is *enter-sleep*.
- **SLEEP**: the gate enable is low and the sleep-status bit reads 1. The machine stays here (*hold-sleep*) until an enabled interrupt or event is pending. It then moves to **WAKE** (*wake-up*).
- **WAKE**: lasts one cycle. The clock runs again, and the machine returns to **RUN** (*resume*) while it clears the sleep-control bit.

The lowest input lines are not wired to any source. A parameter names the first line that is wired, and lines below it can never become pending.

Top module: `ies_ctrl`

## Requirements
- R1: After reset, all enable and pending registers and the sleep-control and sleep-status bits read 0, `irq_req_o` is 0 and `core_clk_en_o` is 1.
- R2: The register map is fixed at these offsets:
  - interrupt enable 0x00, interrupt pending 0x04
  - event enable 0x10, event pending 0x14
  - Enable registers read back the value written.
  - A write to a pending register loads it directly, limited to the live lines.
- R3: A rising edge on a live input line whose enable bit is 1 sets that pending bit at the same clock edge that samples the high level. A line held high does not set the bit again after it is cleared. An edge on a disabled line leaves the pending bit at 0.
- R4: Writing to the set registers sets the pending bits whose data bits are 1. The interrupt set register is at 0x08 and the event set register is at 0x18. Data bits that are 0 leave their pending bits unchanged.
- R5: Writing to the clear registers clears the pending bits whose data bits are 1. The interrupt clear register is at 0x0C and the event clear register is at 0x1C. Data bits that are 0 leave their pending bits unchanged.
- R6: If a hardware edge and a software clear hit the same pending bit in one cycle, the bit ends up set.
- R7: `irq_req_o` is 1 exactly when some interrupt pending bit has its enable bit at 1. Clearing an enable bit keeps the pending bit. Setting the enable bit again restores the request.
- R8: Lines below `LIVE_FROM` (default 23, so bits 22..0) never become pending, whether through an edge, a set write or a direct write.
- R9: Writing 1 to bit 0 at offset 0x20 moves the machine to SLEEP on the next edge. `core_clk_en_o` then reads 0 and bit 0 at 0x24 reads 1.
- R10: In SLEEP, an enabled pending interrupt or event moves the machine to WAKE on the next edge, with `core_clk_en_o` back at 1. One edge later the machine is in RUN and bit 0 at 0x20 reads 0. Pending events never raise `irq_req_o`, and a disabled line's edge does not wake the core.
- R11: A sleep request made while a wake condition already holds gates the clock for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 32 | Interrupt source lines |
| evt_lines_i | input | 32 | Event source lines |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| irq_req_o | output | 1 | Interrupt request to core |
| core_clk_en_o | output | 1 | Core clock-gate enable, active high |

## Verification
Each fault in the internal state shows at the ports one clock edge after it happens:
- A pending bit that is lost or latched by mistake shows in the pending register read-back and in `irq_req_o` right after the edge that should have set it.
- A sleep machine stuck in the wrong state holds `core_clk_en_o` at the wrong level. The enable is compared edge by edge against the one-edge entry and one-edge wake counts.
- A sleep-control bit that is never cleared shows at offset 0x20 two edges after the wake condition.

Walking every line through both banks exposes any swap between line indices and any error at the live-line boundary.

// File: rtl/ies_pkg.sv
package ies_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } sleep_state_e;

    localparam logic [5:0] OFS_IEN     = 6'h00;
    localparam logic [5:0] OFS_IPEND   = 6'h04;
    localparam logic [5:0] OFS_ISET    = 6'h08;
    localparam logic [5:0] OFS_ICLR    = 6'h0C;
    localparam logic [5:0] OFS_EEN     = 6'h10;
    localparam logic [5:0] OFS_EPEND   = 6'h14;
    localparam logic [5:0] OFS_ESET    = 6'h18;
    localparam logic [5:0] OFS_ECLR    = 6'h1C;
    localparam logic [5:0] OFS_SLPCTL  = 6'h20;
    localparam logic [5:0] OFS_SLPSTAT = 6'h24;
endpackage

// File: rtl/ies_pend_bank.sv
module ies_pend_bank #(
    parameter int N         = 32,
    parameter int LIVE_FROM = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic         en_we_i,
    input  logic         pend_we_i,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] pend_o,
    output logic         req_o
);
    localparam logic [N-1:0] LIVE_MASK = {N{1'b1}} << LIVE_FROM;

    logic [N-1:0] prev_q, en_q, pend_q, pend_d, hw_set;

    assign hw_set = lines_i & ~prev_q & en_q & LIVE_MASK;

    always_comb begin
        pend_d = pend_we_i ? wdata_i : pend_q;
        if (clr_we_i) pend_d = pend_d & ~wdata_i;
        if (set_we_i) pend_d = pend_d | wdata_i;
        pend_d = (pend_d | hw_set) & LIVE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lines_i;
            pend_q <= pend_d;
            if (en_we_i) en_q <= wdata_i;
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign req_o  = |(pend_q & en_q);

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((pend_q & $past(hw_set)) == $past(hw_set))); // R6

    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_we_i && !set_we_i && !clr_we_i && hw_set == '0) |=> $stable(pend_q)); // R3
endmodule

// File: rtl/ies_sleep_fsm.sv
module ies_sleep_fsm
    import ies_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_i,
    input  logic wake_i,
    output logic clk_en_o,
    output logic asleep_o,
    output logic wake_done_o
);
    sleep_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep_req_i) state_d = ST_SLEEP;
            ST_SLEEP: if (wake_i)      state_d = ST_WAKE;
            ST_WAKE:                   state_d = ST_RUN;
            default:                   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        clk_en_o    = 1'b1;
        asleep_o    = 1'b0;
        wake_done_o = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_SLEEP: begin
                clk_en_o = 1'b0;
                asleep_o = 1'b1;
            end
            ST_WAKE:  wake_done_o = 1'b1;
            default: ;
        endcase
    end

    AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req_i) |=> (state_q == ST_SLEEP)); // R9

    AST_HOLD_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !wake_i) |=> (state_q == ST_SLEEP)); // R10

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> (state_q == ST_RUN)); // R10
endmodule

// File: rtl/ies_ctrl.sv
module ies_ctrl
    import ies_pkg::*;
#(
    parameter int N         = 32,
    parameter int LIVE_FROM = 23,
    parameter int DW        = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_lines_i,
    input  logic [N-1:0]  evt_lines_i,
    input  logic          bus_valid_i,
    input  logic          bus_write_i,
    input  logic [5:0]    bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_req_o,
    output logic          core_clk_en_o
);
    logic         wr;
    logic [N-1:0] ien, ipend, een, epend;
    logic         irq_any, evt_any;
    logic         sleep_bit_q, asleep, wake_done;

    assign wr = bus_valid_i & bus_write_i;

    ies_pend_bank #(.N(N), .LIVE_FROM(LIVE_FROM)) u_irq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_i   (irq_lines_i),
        .en_we_i   (wr && bus_addr_i == OFS_IEN),
        .pend_we_i (wr && bus_addr_i == OFS_IPEND),
        .set_we_i  (wr && bus_addr_i == OFS_ISET),
        .clr_we_i  (wr && bus_addr_i == OFS_ICLR),
        .wdata_i   (bus_wdata_i[N-1:0]),
        .en_o      (ien),
        .pend_o    (ipend),
        .req_o     (irq_any)
    );

    ies_pend_bank #(.N(N), .LIVE_FROM(LIVE_FROM)) u_evt_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_i   (evt_lines_i),
        .en_we_i   (wr && bus_addr_i == OFS_EEN),
        .pend_we_i (wr && bus_addr_i == OFS_EPEND),
        .set_we_i  (wr && bus_addr_i == OFS_ESET),
        .clr_we_i  (wr && bus_addr_i == OFS_ECLR),
        .wdata_i   (bus_wdata_i[N-1:0]),
        .en_o      (een),
        .pend_o    (epend),
        .req_o     (evt_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              sleep_bit_q <= 1'b0;
        else if (wake_done)                      sleep_bit_q <= 1'b0;
        else if (wr && bus_addr_i == OFS_SLPCTL) sleep_bit_q <= bus_wdata_i[0];
    end

    ies_sleep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_bit_q),
        .wake_i      (irq_any | evt_any),
        .clk_en_o    (core_clk_en_o),
        .asleep_o    (asleep),
        .wake_done_o (wake_done)
    );

    always_comb begin
        unique case (bus_addr_i)
            OFS_IEN:     bus_rdata_o = DW'(ien);
            OFS_IPEND:   bus_rdata_o = DW'(ipend);
            OFS_EEN:     bus_rdata_o = DW'(een);
            OFS_EPEND:   bus_rdata_o = DW'(epend);
            OFS_SLPCTL:  bus_rdata_o = DW'(sleep_bit_q);
            OFS_SLPSTAT: bus_rdata_o = DW'(asleep);
            default:     bus_rdata_o = '0;
        endcase
    end

    assign irq_req_o = irq_any;

    AST_WAKE_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !sleep_bit_q); // R10

    AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en_o) |-> $past(sleep_bit_q)); // R9
endmodule

// File: tb/ies_ctrl_tb.sv
module ies_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0, evt_lines = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq_req, core_clk_en;

    int total = 0, fails = 0;
    localparam logic [31:0] LIVE = 32'hFF80_0000;

    always #5 clk = ~clk;

    ies_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .irq_lines_i(irq_lines), .evt_lines_i(evt_lines),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_req_o(irq_req), .core_clk_en_o(core_clk_en)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input bit is_evt, input int i);
        @(negedge clk);
        if (is_evt) evt_lines = 32'd1 << i; else irq_lines = 32'd1 << i;
        @(negedge clk);
        evt_lines = '0; irq_lines = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a <= 9; a++) begin
            rd(6'(a * 4), v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 irq_req", {31'b0, irq_req}, 0);
        chk("R1 clk_en", {31'b0, core_clk_en}, 1);

        // R2 enable readback
        wr(6'h00, 32'hA5A5_0F0F); rd(6'h00, v); chk("R2 ien", v, 32'hA5A5_0F0F);
        wr(6'h10, 32'h5A5A_F0F0); rd(6'h10, v); chk("R2 een", v, 32'h5A5A_F0F0);

        // R3/R8 sweep: every interrupt line, all enabled
        wr(6'h00, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            pulse(1'b0, i);
            exp = (32'd1 << i) & LIVE;
            rd(6'h04, v); chk("R3 R8 irq edge pend", v, exp);
            chk("R7 irq_req follows pend", {31'b0, irq_req}, {31'b0, exp != 0});
            wr(6'h0C, 32'd1 << i); rd(6'h04, v); chk("R5 irq clear", v, 0);
        end
        // sweep event lines; events never raise irq
        wr(6'h10, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            pulse(1'b1, i);
            exp = (32'd1 << i) & LIVE;
            rd(6'h14, v); chk("R3 R8 evt edge pend", v, exp);
            chk("R10 evt no irq", {31'b0, irq_req}, 0);
            wr(6'h1C, 32'd1 << i); rd(6'h14, v); chk("R5 evt clear", v, 0);
        end

        // R3 disabled lines ignored
        wr(6'h00, 32'h0); wr(6'h10, 32'h0);
        @(negedge clk); irq_lines = '1; evt_lines = '1;
        @(negedge clk); irq_lines = '0; evt_lines = '0;
        rd(6'h04, v); chk("R3 disabled irq", v, 0);
        rd(6'h14, v); chk("R3 disabled evt", v, 0);

        // R3 held level does not retrigger
        wr(6'h00, 32'hFFFF_FFFF);
        @(negedge clk); irq_lines = 32'h0100_0000;
        rd(6'h04, v); chk("R3 level sets", v, 32'h0100_0000);
        wr(6'h0C, 32'h0100_0000);
        repeat (3) @(negedge clk);
        rd(6'h04, v); chk("R3 held no retrigger", v, 0);
        irq_lines = '0;

        // R4/R5/R8 software set, clear, direct write
        wr(6'h08, 32'hFFFF_FFFF); rd(6'h04, v); chk("R4 R8 set all", v, LIVE);
        wr(6'h0C, 32'h0F00_0000); rd(6'h04, v); chk("R5 partial clear", v, 32'hF080_0000);
        wr(6'h08, 32'h0000_0000); rd(6'h04, v); chk("R4 zero set no effect", v, 32'hF080_0000);
        wr(6'h0C, 32'h0000_0000); rd(6'h04, v); chk("R5 zero clear no effect", v, 32'hF080_0000);
        wr(6'h04, 32'h1234_5678); rd(6'h04, v); chk("R2 R8 direct write", v, 32'h1200_0000);
        wr(6'h18, 32'h0080_0001); rd(6'h14, v); chk("R4 R8 evt set", v, 32'h0080_0000);
        wr(6'h14, 32'h0); rd(6'h14, v); chk("R2 evt direct write", v, 0);

        // R7 enable mask after pending
        wr(6'h04, 32'h0); wr(6'h08, 32'h0200_0000);
        chk("R7 irq set", {31'b0, irq_req}, 1);
        wr(6'h00, 32'h0);
        chk("R7 irq masked", {31'b0, irq_req}, 0);
        rd(6'h04, v); chk("R7 pend kept", v, 32'h0200_0000);
        wr(6'h00, 32'h0200_0000);
        chk("R7 irq restored", {31'b0, irq_req}, 1);

        // R6 hardware set beats software clear in same cycle
        wr(6'h04, 32'h0100_0000); wr(6'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_lines = 32'h0200_0000;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h0300_0000;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; irq_lines = '0;
        rd(6'h04, v); chk("R6 set wins", v, 32'h0200_0000);

        // R9/R10 sleep and interrupt wake
        wr(6'h04, 32'h0); wr(6'h00, 32'h1000_0000); wr(6'h10, 32'h0);
        wr(6'h20, 32'h1);
        chk("R9 clk_en before entry", {31'b0, core_clk_en}, 1);
        @(negedge clk);
        chk("R9 clk_en gated", {31'b0, core_clk_en}, 0);
        rd(6'h24, v); chk("R9 status asleep", v, 1);
        pulse(1'b1, 30);
        pulse(1'b0, 29);
        repeat (2) @(negedge clk);
        chk("R10 disabled lines no wake", {31'b0, core_clk_en}, 0);
        @(negedge clk); irq_lines = 32'h1000_0000;
        @(negedge clk); irq_lines = '0;
        chk("R10 still gated at pend edge", {31'b0, core_clk_en}, 0);
        @(negedge clk);
        chk("R10 wake clk_en", {31'b0, core_clk_en}, 1);
        #1 bus_addr = 6'h24; #1 chk("R10 status cleared", bus_rdata, 0);
        bus_addr = 6'h20; #1 chk("R10 ctl held in wake", bus_rdata, 1);
        rd(6'h20, v); chk("R10 ctl cleared in run", v, 0);
        chk("R10 clk_en run", {31'b0, core_clk_en}, 1);

        // R10 event wake, no irq
        wr(6'h04, 32'h0); wr(6'h00, 32'h0); wr(6'h10, 32'h0400_0000);
        wr(6'h20, 32'h1);
        @(negedge clk);
        chk("R9 gated again", {31'b0, core_clk_en}, 0);
        pulse(1'b1, 26);
        @(negedge clk);
        chk("R10 evt wake", {31'b0, core_clk_en}, 1);
        chk("R10 evt wake no irq", {31'b0, irq_req}, 0);
        rd(6'h20, v); chk("R10 evt ctl cleared", v, 0);

        // R11 sleep with wake already pending
        wr(6'h20, 32'h1);
        @(negedge clk);
        chk("R11 one gated cycle", {31'b0, core_clk_en}, 0);
        @(negedge clk);
        chk("R11 immediate wake", {31'b0, core_clk_en}, 1);
        @(negedge clk);
        rd(6'h20, v); chk("R11 ctl cleared", v, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule